// File: doc/BRIEF.md
# Configurable Serial Transmitter

This block turns a parallel byte into a serial bit stream on a single TXD line. It supports two framings. In asynchronous framing it sends a start bit, a 7- or 8-bit character, an optional parity bit and one or two stop bits, timed by a 16x oversampling tick. In clock-synchronous framing it shifts exactly eight data bits against a serial clock, with no framing bits.

The clock for either framing comes from one of two places. It can come from an internal programmable divider, or from the SCK pin, which is then an input. The SCK pin has four possible roles, chosen by the framing bit and a two-bit clock-select field. It can be left undriven. It can carry a 16x clock out of the block. It can carry a 16x clock into the block. It can carry the serial clock, driven by the block or supplied by a partner.

A host presents a byte with a valid/ready handshake. Mode, clock-select and divider inputs must be held stable while a character is in flight.

Top module: `sertx_top`

## Requirements
- R1: After reset, txd is 1 and tx_ready is 1. tx_ready is 0 from the cycle after a byte is accepted (tx_valid and tx_ready both high at a clock edge) until the character has finished, and txd is 1 whenever tx_ready is 1.
- R2: With mode_sync=0, the asynchronous character starts with one 0 start bit, followed by data bits least significant first. There are 8 data bits when mode_chr7=0, and only tx_data[6:0] are sent when mode_chr7=1.
- R3: With mode_sync=0 and mode_par_en=1, a parity bit follows the last data bit. It makes the count of ones over data and parity even when mode_par_odd=0 and odd when mode_par_odd=1. With mode_par_en=0, no parity bit is sent.
- R4: With mode_sync=0, the character ends with one stop bit (mode_stop2=0) or two stop bits (mode_stop2=1), each at 1. tx_ready stays 0 through the centre of the last stop bit and is 1 again within half a bit after it.
- R5: With mode_sync=0 and cks[1]=0, every bit lasts 16*(baud_div+1) clock cycles, and the whole character lasts that times its bit count.
- R6: With mode_sync=1, exactly 8 data bits are sent least significant first, with no start, parity or stop bits. mode_chr7, mode_par_en and mode_stop2 have no effect.
- R7: With mode_sync=1 and cks[1]=0, sck_oe=1 and sck_o is 1 while idle. During each bit, sck_o is 0 for the first 8 ticks and 1 for the last 8 ticks, so one bit lasts 16*(baud_div+1) cycles. txd changes only when sck_o falls.
- R8: With mode_sync=1 and cks[1]=1, sck_oe=0 and sck_i is the serial clock. It passes through a two-flop synchronizer. Bit k is put on txd after the k-th falling edge of sck_i following acceptance, and the character ends at the 8th rising edge. With no falling edge, txd stays 1.
- R9: With mode_sync=0, cks=00 gives sck_oe=0. cks=01 gives sck_oe=1, with sck_o a clock of period baud_div+1 cycles, which is 16 times the bit rate.
- R10: With mode_sync=0 and cks[1]=1, sck_oe=0. Each synchronized rising edge of sck_i is one oversampling tick, so a bit lasts 16 periods of sck_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on tx_data is offered |
| tx_ready | output | 1 | Transmitter idle, byte will be taken |
| mode_sync | input | 1 | 0 asynchronous framing, 1 clock-synchronous |
| mode_chr7 | input | 1 | Asynchronous: 1 selects 7 data bits |
| mode_par_en | input | 1 | Asynchronous: 1 adds a parity bit |
| mode_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| mode_stop2 | input | 1 | Asynchronous: 1 selects two stop bits |
| cks | input | 2 | Clock select for the SCK pin role |
| baud_div | input | DIV_W | Divider: one tick every baud_div+1 cycles |
| txd | output | 1 | Serial data line, idles high |
| sck_o | output | 1 | SCK pin output value |
| sck_oe | output | 1 | SCK pin output enable |
| sck_i | input | 1 | SCK pin input value |

## Verification
The transmit line leaves idle on the clock edge after the first tick that follows acceptance. After that, every asynchronous bit boundary falls exactly 16*(baud_div+1) cycles later, so the bench finds the falling start edge and samples each bit at its centre by counting from that edge. tx_ready drops one cycle after acceptance. It returns on the edge that closes the last bit, and the bench checks that count exactly in cycles. In synchronous mode with an external clock, the synchronizer and the state register place the new txd value about three cycles after an sck_i fall. The bench therefore holds each sck_i phase for six cycles and samples txd just before raising sck_i. All sampling is done on falling clock edges.

// File: rtl/sertx_pkg.sv
// Package: shared constants, mode record and frame-building functions
// for the configurable serial transmitter. Frame bit 0 is sent first.
package sertx_pkg;

    localparam int DATA_W    = 8;   // character register width
    localparam int FRAME_W   = 12;  // start + 8 data + parity + 2 stops
    localparam int OVERSMP   = 16;  // ticks per bit
    localparam int CNT_W     = $clog2(OVERSMP);
    localparam int HALF_TICK = OVERSMP / 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic sync;
        logic chr7;
        logic par_en;
        logic par_odd;
        logic stop2;
    } tx_mode_t;

    // Lay out the complete character, padding unused upper bits with 1.
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [DATA_W-1:0] d,
        input tx_mode_t          m
    );
        logic [FRAME_W-1:0] f;
        logic               p;
        f = '1;
        if (m.sync) begin
            f[DATA_W-1:0] = d;
        end else begin
            p    = m.par_odd;
            f[0] = 1'b0;
            for (int i = 0; i < DATA_W; i++) begin
                if (!(m.chr7 && i == DATA_W - 1)) begin
                    f[i+1] = d[i];
                    p      = p ^ d[i];
                end
            end
            if (m.par_en) begin
                if (m.chr7) f[DATA_W]   = p;
                else        f[DATA_W+1] = p;
            end
        end
        return f;
    endfunction

    // Number of bit times in the character for the given mode.
    function automatic logic [CNT_W-1:0] frame_len(input tx_mode_t m);
        logic [CNT_W-1:0] n;
        if (m.sync) begin
            n = CNT_W'(DATA_W);
        end else begin
            n = m.chr7 ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W + 2);
            if (m.par_en) n = n + CNT_W'(1);
            if (m.stop2)  n = n + CNT_W'(1);
        end
        return n;
    endfunction

endpackage

// File: rtl/sertx_clkgen.sv
// Clock generation: a free-running divider producing one oversampling tick
// every baud_div+1 cycles plus a 16x pin clock derived from it, and a
// synchronizer with edge detection for a clock arriving on the SCK pin.
// Assumes baud_div >= 1 when the 16x pin clock is used.
module sertx_clkgen #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             ext_sel,
    input  logic             sck_i,
    output logic             tick,
    output logic             sck16,
    output logic             ext_rise,
    output logic             ext_fall
);

    logic [DIV_W-1:0]     div_cnt;
    logic [SYNC_STAGES:0] sync_q;
    logic                 tick_int;

    assign tick_int = (div_cnt >= baud_div);

    // Divider: wrap at baud_div so the tick period is baud_div+1 cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_cnt <= '0;
        else if (tick_int) div_cnt <= '0;
        else               div_cnt <= div_cnt + DIV_W'(1);
    end

    // Synchronizer chain with one extra stage kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], sck_i};
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign ext_fall = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];
    assign sck16    = (div_cnt > (baud_div >> 1));
    assign tick     = ext_sel ? ext_rise : tick_int;

endmodule

// File: rtl/sertx_shifter.sv
// Shift engine: loads a prepared frame, waits for the first clock event,
// then presents one bit at a time on txd. With tick timing, each bit spans
// OVERSMP ticks; with an external serial clock, bits advance on falling
// edges and the character closes on the rising edge of the last bit.
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [CNT_W-1:0]   len_in,
    input  logic               ext_sclk,
    input  logic               tick,
    input  logic               sck_rise,
    input  logic               sck_fall,
    output logic               ready,
    output logic               txd,
    output logic               sclk_int
);

    localparam logic [CNT_W-1:0] SUB_LAST = CNT_W'(OVERSMP - 1);
    localparam logic [CNT_W-1:0] SUB_HALF = CNT_W'(HALF_TICK);

    tx_state_e          state;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bits_left;
    logic [CNT_W-1:0]   sub_cnt;
    logic               start_evt;
    logic               last_bit;

    assign start_evt = ext_sclk ? sck_fall : tick;
    assign last_bit  = (bits_left == CNT_W'(1));

    // Sequencer: load, wait for first clock event, shift out, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '1;
            bits_left <= '0;
            sub_cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        shreg     <= frame_in;
                        bits_left <= len_in;
                        state     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (start_evt) begin
                        state   <= ST_RUN;
                        sub_cnt <= '0;
                    end
                end
                ST_RUN: begin
                    if (ext_sclk) begin
                        if (sck_fall) begin
                            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
                            bits_left <= bits_left - CNT_W'(1);
                        end else if (sck_rise && last_bit) begin
                            state <= ST_IDLE;
                            shreg <= '1;
                        end
                    end else if (tick) begin
                        sub_cnt <= sub_cnt + CNT_W'(1);
                        if (sub_cnt == SUB_LAST) begin
                            if (last_bit) begin
                                state <= ST_IDLE;
                                shreg <= '1;
                            end else begin
                                shreg     <= {1'b1, shreg[FRAME_W-1:1]};
                                bits_left <= bits_left - CNT_W'(1);
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ready    = (state == ST_IDLE);
    assign txd      = (state == ST_RUN) ? shreg[0] : 1'b1;
    assign sclk_int = !((state == ST_RUN) && (sub_cnt < SUB_HALF));

endmodule

// File: rtl/sertx_top.sv
// Configurable serial transmitter top: builds the frame for the current
// mode when a byte is accepted, runs the shift engine from the selected
// clock source and sets the SCK pin role. Assumes the mode bits, cks and
// baud_div change only while tx_ready is high.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              mode_sync,
    input  logic              mode_chr7,
    input  logic              mode_par_en,
    input  logic              mode_par_odd,
    input  logic              mode_stop2,
    input  logic [1:0]        cks,
    input  logic [DIV_W-1:0]  baud_div,
    output logic              txd,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i
);

    tx_mode_t mode;
    logic     tick;
    logic     sck16;
    logic     ext_rise;
    logic     ext_fall;
    logic     sclk_int;
    logic     accept;

    assign mode   = {mode_sync, mode_chr7, mode_par_en, mode_par_odd, mode_stop2};
    assign accept = tx_valid && tx_ready;

    sertx_clkgen #(
        .DIV_W      (DIV_W),
        .SYNC_STAGES(2)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .baud_div(baud_div),
        .ext_sel (cks[1]),
        .sck_i   (sck_i),
        .tick    (tick),
        .sck16   (sck16),
        .ext_rise(ext_rise),
        .ext_fall(ext_fall)
    );

    sertx_shifter u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .frame_in (build_frame(tx_data, mode)),
        .len_in   (frame_len(mode)),
        .ext_sclk (mode_sync && cks[1]),
        .tick     (tick),
        .sck_rise (ext_rise),
        .sck_fall (ext_fall),
        .ready    (tx_ready),
        .txd      (txd),
        .sclk_int (sclk_int)
    );

    // SCK pin role: chosen by framing bit and clock select.
    always_comb begin
        if (mode_sync) begin
            sck_oe = !cks[1];
            sck_o  = cks[1] ? 1'b1 : sclk_int;
        end else begin
            sck_oe = (cks == 2'b01);
            sck_o  = (cks == 2'b01) ? sck16 : 1'b0;
        end
    end

endmodule

// File: rtl/sertx_chk.sv
// Checker for sertx_top: handshake, idle line level and SCK pin role
// properties, attached to every instance of the top through bind.
module sertx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       txd,
    input logic       mode_sync,
    input logic [1:0] cks,
    input logic       sck_o,
    input logic       sck_oe
);

    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    // R9
    async_pin_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sync && cks == 2'b00) |-> !sck_oe);

    // R9
    async_pin_x16_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sync && cks == 2'b01) |-> sck_oe);

    // R10 and R8
    ext_clk_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cks[1] |-> !sck_oe);

    // R7
    sync_clk_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sync && !cks[1]) |-> sck_oe);

    // R7
    sync_clk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sync && !cks[1] && tx_ready) |-> sck_o);

    // R7
    sync_data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sync && !cks[1] && !tx_ready && !$stable(txd)) |-> $fell(sck_o));

endmodule

bind sertx_top sertx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd),
    .mode_sync(mode_sync),
    .cks      (cks),
    .sck_o    (sck_o),
    .sck_oe   (sck_oe)
);

// File: tb/sertx_top_tb.sv
// Bench: sweeps all asynchronous format combinations, both SCK roles in
// each framing, and checks bit values and timing against arithmetic models.
module sertx_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       mode_sync = 1'b0;
    logic       mode_chr7 = 1'b0;
    logic       mode_par_en = 1'b0;
    logic       mode_par_odd = 1'b0;
    logic       mode_stop2 = 1'b0;
    logic [1:0] cks = 2'b00;
    logic [7:0] baud_div = 8'd1;
    logic       txd;
    logic       sck_o;
    logic       sck_oe;
    logic       sck_i;
    logic       ext16_en = 1'b0;
    logic       ext16_clk = 1'b1;
    logic       sck_drv = 1'b1;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    assign sck_i = ext16_en ? ext16_clk : sck_drv;

    sertx_top #(.DIV_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .mode_sync(mode_sync), .mode_chr7(mode_chr7),
        .mode_par_en(mode_par_en), .mode_par_odd(mode_par_odd),
        .mode_stop2(mode_stop2), .cks(cks), .baud_div(baud_div), .txd(txd),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i)
    );

    // External 16x clock: period 8 cycles while enabled.
    initial begin
        forever begin
            repeat (4) @(negedge clk);
            if (ext16_en) ext16_clk = ~ext16_clk;
            else          ext16_clk = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Offer one byte; it is taken at the next edge since the block is idle.
    task automatic send(input logic [7:0] d);
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R1", "ready low after accept", tx_ready, 0);
    endtask

    // Expected asynchronous character, bit 0 first, padded with ones.
    function automatic int exp_frame(input logic [7:0] d, input bit c7,
                                     input bit pe, input bit po);
        int dl;
        int v;
        int par;
        int f;
        int used;
        dl   = c7 ? 7 : 8;
        v    = c7 ? int'(d & 8'h7F) : int'(d);
        par  = ($countones(v) % 2) ^ int'(po);
        f    = v << 1;
        if (pe) f = f | (par << (1 + dl));
        used = 1 + dl + (pe ? 1 : 0);
        f    = f | (32'hFFF & ~((1 << used) - 1));
        return f & 32'hFFF;
    endfunction

    // Receive an asynchronous character with bit period p cycles.
    task automatic rx_async(input int p, input int n, output int got,
                            output bit rdy_mid, output bit rdy_end);
        int guard;
        guard = 0;
        got   = 32'hFFF;
        while (txd !== 1'b0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (p / 2) @(negedge clk);
        got[0] = txd;
        for (int k = 1; k < n; k++) begin
            repeat (p) @(negedge clk);
            got[k] = txd;
        end
        rdy_mid = tx_ready;
        repeat (p / 2 + 2) @(negedge clk);
        rdy_end = tx_ready;
    endtask

    task automatic async_case(input logic [7:0] d, input int p, input string tag);
        int  got;
        int  exp;
        int  n;
        bit  rm;
        bit  re;
        exp = exp_frame(d, mode_chr7, mode_par_en, mode_par_odd);
        n   = 1 + (mode_chr7 ? 7 : 8) + (mode_par_en ? 1 : 0) + 1 + (mode_stop2 ? 1 : 0);
        send(d);
        rx_async(p, n, got, rm, re);
        check(got == exp, tag, "async character bits", got, exp);
        check(rm == 1'b0, "R4", "ready low at last stop centre", rm, 0);
        check(re == 1'b1, "R4", "ready back after last stop", re, 1);
    endtask

    // Sync mode with internal serial clock: sample txd on sck_o rises.
    task automatic sync_int_case(input logic [7:0] d);
        int   rises;
        int   guard;
        int   t;
        int   t_first;
        int   t_second;
        logic prev;
        logic [7:0] got;
        check(sck_o == 1'b1, "R7", "sck idles high", sck_o, 1);
        check(sck_oe == 1'b1, "R7", "sck driven", sck_oe, 1);
        send(d);
        rises = 0; guard = 0; t = 0; t_first = 0; t_second = 0;
        got = 8'h00;
        prev = sck_o;
        while (!tx_ready && guard < 5000) begin
            @(negedge clk);
            guard++; t++;
            if (!prev && sck_o) begin
                if (rises < 8) got[rises] = txd;
                if (rises == 0) t_first = t;
                if (rises == 1) t_second = t;
                rises++;
            end
            prev = sck_o;
        end
        check(got == d, "R6", "sync data bits", got, d);
        check(rises == 8, "R6", "sync clock count", rises, 8);
        check(t_second - t_first == 16 * (int'(baud_div) + 1), "R7",
              "sync bit period", t_second - t_first, 16 * (int'(baud_div) + 1));
    endtask

    // Sync mode with external serial clock driven by the bench.
    task automatic sync_ext_case(input logic [7:0] d);
        logic [7:0] got;
        got = 8'h00;
        send(d);
        repeat (20) @(negedge clk);
        check(txd == 1'b1, "R8", "txd holds before first fall", txd, 1);
        for (int k = 0; k < 8; k++) begin
            sck_drv = 1'b0;
            repeat (6) @(negedge clk);
            got[k] = txd;
            if (k == 7) check(tx_ready == 1'b0, "R8", "busy before last rise", tx_ready, 0);
            sck_drv = 1'b1;
            repeat (6) @(negedge clk);
        end
        check(got == d, "R8", "ext sync data bits", got, d);
        check(tx_ready == 1'b1, "R8", "done after 8th rise", tx_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int cnt;
        int n;
        int edges;
        logic prev;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1", "txd after reset", txd, 1);
        check(tx_ready == 1'b1, "R1", "ready after reset", tx_ready, 1);
        check(sck_oe == 1'b0, "R9", "pin unused with cks 00", sck_oe, 0);

        // R2 R3 R4: every asynchronous format, internal clock
        baud_div = 8'd1;
        for (int cfg = 0; cfg < 16; cfg++) begin
            mode_chr7    = cfg[0];
            mode_par_en  = cfg[1];
            mode_par_odd = cfg[2];
            mode_stop2   = cfg[3];
            async_case(8'h80 | 8'(cfg), 32, "R2/R3/R4");
            async_case(~8'(cfg * 13), 32, "R2/R3/R4");
            async_case(8'(cfg * 29 + 3), 32, "R2/R3/R4");
        end

        // R5 exact character duration at another divider
        baud_div = 8'd2; mode_chr7 = 1'b0; mode_par_en = 1'b1; mode_stop2 = 1'b1;
        n = 12;
        send(8'h5A);
        cnt = 0;
        while (txd !== 1'b0 && cnt < 1000) begin @(negedge clk); cnt++; end
        cnt = 0;
        while (!tx_ready && cnt < 5000) begin @(negedge clk); cnt++; end
        check(cnt == n * 48, "R5", "character duration cycles", cnt, n * 48);

        // R9 16x pin clock
        baud_div = 8'd3; cks = 2'b01;
        @(negedge clk);
        check(sck_oe == 1'b1, "R9", "16x clock driven", sck_oe, 1);
        edges = 0; prev = sck_o;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (sck_o != prev) edges++;
            prev = sck_o;
        end
        check(edges == 16, "R9", "16x clock transitions in 32 cycles", edges, 16);

        // R10 external 16x clock, period 8 cycles
        cks = 2'b10; ext16_en = 1'b1;
        repeat (20) @(negedge clk);
        check(sck_oe == 1'b0, "R10", "pin is input", sck_oe, 0);
        mode_chr7 = 1'b0; mode_par_en = 1'b1; mode_par_odd = 1'b0; mode_stop2 = 1'b0;
        async_case(8'hC3, 128, "R10");
        mode_chr7 = 1'b1; mode_par_odd = 1'b1; mode_stop2 = 1'b1;
        async_case(8'h96, 128, "R10");
        ext16_en = 1'b0;
        repeat (10) @(negedge clk);

        // R6 R7 sync, internal clock, async format bits set to show no effect
        mode_sync = 1'b1; cks = 2'b00; baud_div = 8'd1;
        mode_chr7 = 1'b1; mode_par_en = 1'b1; mode_stop2 = 1'b1;
        @(negedge clk);
        sync_int_case(8'hB1);
        mode_chr7 = 1'b0; mode_par_en = 1'b0; mode_stop2 = 1'b0;
        sync_int_case(8'h4E);

        // R8 sync, external clock
        cks = 2'b10;
        @(negedge clk);
        check(sck_oe == 1'b0, "R8", "pin is input", sck_oe, 0);
        sync_ext_case(8'hD2);
        mode_chr7 = 1'b1;
        sync_ext_case(8'h81);

        summary();
        $finish;
    end

endmodule